// File: doc/BRIEF.md
# Custom Glyph RAM Row Fetch

This block sits in the character path of a dot-matrix display controller. For each request it takes an 8-bit character code and a row index (0 to 7) and, one cycle later, produces the 5-bit dot pattern for that row of that character. Codes whose six high bits are zero select one of four user-defined glyphs kept in a small internal glyph RAM. Every other code is passed, together with the row, to an external font ROM port, and the ROM's row is steered back to the output.

The block also applies the cursor and blink overlay for the cell under the cursor. A host write port fills the glyph RAM one row at a time. The RAM is never cleared by reset, so glyphs survive a reset.

Top module: `glyph_row_fetch`

## Requirements
- R1: While reset is asserted and after it, until a request is accepted, `out_valid`, `rom_rd` and `pix_row` are all zero.
- R2: A request sampled with `req_valid` high at a clock edge gives `out_valid` high for exactly the following cycle, with its `pix_row` in that cycle. A cycle without a request gives no result.
- R3: A code with bits 7 to 2 all zero reads the glyph RAM at address {code[1:0], row}, where code bits 1:0 are address bits 4:3 and the row is address bits 2:0. `pix_row` bit n (n = 0..4) is dot n, with 1 meaning on.
- R4: For any other code, `rom_addr` becomes {code, row} (code in bits 10:3, row in bits 2:0) in the result cycle. `rom_rd` is high in that cycle, and `pix_row` equals `rom_data` in the same cycle.
- R5: A user-glyph request leaves `rom_addr` unchanged from the last font request and keeps `rom_rd` low.
- R6: With `wr_en` high at a clock edge, `wr_data` is stored at glyph RAM address `wr_addr`. Any later request for that address returns it.
- R7: Glyph RAM contents are kept across a reset.
- R8: Dots set in row 7 of a user glyph are shown as stored, whether or not the cursor is enabled or the cell is the cursor cell.
- R9: With `cursor_en` high and `req_on_cursor` high on a row-7 request, the result is 5'b11111. Other rows of the cursor cell, and row 7 of other cells, are not changed by `cursor_en`.
- R10: With `blink_en` high and `req_on_cursor` high, a request returns 5'b11111 on every row whenever the blink phase is 1. The phase is bit BLINK_DIV_W of a counter that is zero in reset and counts every clock after it, sampled at the request edge. `blink_en` does not change cells other than the cursor cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Row request strobe |
| req_code | input | 8 | Character code |
| req_row | input | 3 | Row index 0..7 |
| req_on_cursor | input | 1 | Requested cell is the cursor cell |
| cursor_en | input | 1 | Cursor underline enable |
| blink_en | input | 1 | Cursor-cell blink enable |
| wr_en | input | 1 | Glyph RAM write strobe |
| wr_addr | input | 5 | Glyph RAM write address {glyph, row} |
| wr_data | input | 5 | Glyph RAM row data |
| rom_rd | output | 1 | Font ROM row in use this cycle |
| rom_addr | output | 11 | Font ROM address {code, row} |
| rom_data | input | 5 | Font ROM row returned for `rom_addr` |
| out_valid | output | 1 | Result strobe |
| pix_row | output | 5 | Resulting dot row |

## Verification
A wrong decode of the user-glyph range shows up in the result cycle of the first request for a code from 4 to 255 or from 0 to 3. The font port either moves when it should hold or holds when it should move. A corrupted glyph RAM word or swapped address bits show on the next request for that glyph row, so every one of the 32 words is read back. A wrong blink divider or overlay state appears within one blink period, as a cursor-cell row whose value disagrees with the phase the bench tracks.

// File: rtl/gfetch_pkg.sv
package gfetch_pkg;
  localparam int CODE_W = 8;   // character code width
  localparam int ROW_W  = 3;   // row index width (8 rows)
  localparam int DOT_W  = 5;   // dots per row
  localparam int SEL_W  = 2;   // glyph select bits (4 user glyphs)

  typedef struct packed {
    logic             user;      // result comes from the glyph RAM
    logic             underline; // cursor underline applies
    logic             blink_on;  // blink phase forces all dots
  } stage_t;
endpackage

// File: rtl/glyph_store.sv
module glyph_store
  import gfetch_pkg::*;
#(
  parameter int ADDR_W = SEL_W + ROW_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DOT_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DOT_W-1:0]  rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DOT_W-1:0] mem_q [DEPTH];
  logic [DOT_W-1:0] rd_q;

  // Storage has no reset: contents survive a block reset.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_q <= mem_q[rd_addr];
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/blink_div.sv
module blink_div #(
  parameter int DIV_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  logic [DIV_W:0] cnt_q;
  logic [DIV_W:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign phase = cnt_q[DIV_W];
endmodule

// File: rtl/row_overlay.sv
module row_overlay
  import gfetch_pkg::*;
(
  input  stage_t           st,
  input  logic [DOT_W-1:0] ram_row,
  input  logic [DOT_W-1:0] rom_row,
  output logic [DOT_W-1:0] pix
);
  always_comb begin
    pix = st.user ? ram_row : rom_row;
    if (st.blink_on || st.underline) begin
      pix = '1;
    end
  end
endmodule

// File: rtl/glyph_row_fetch.sv
module glyph_row_fetch
  import gfetch_pkg::*;
#(
  parameter int BLINK_DIV_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [CODE_W-1:0]        req_code,
  input  logic [ROW_W-1:0]         req_row,
  input  logic                     req_on_cursor,
  input  logic                     cursor_en,
  input  logic                     blink_en,
  input  logic                     wr_en,
  input  logic [SEL_W+ROW_W-1:0]   wr_addr,
  input  logic [DOT_W-1:0]         wr_data,
  output logic                     rom_rd,
  output logic [CODE_W+ROW_W-1:0]  rom_addr,
  input  logic [DOT_W-1:0]         rom_data,
  output logic                     out_valid,
  output logic [DOT_W-1:0]         pix_row
);
  localparam int GA_W   = SEL_W + ROW_W;
  localparam int RADDR_W = CODE_W + ROW_W;

  logic               user_sel;
  logic               phase;
  logic [DOT_W-1:0]   ram_row;
  logic [DOT_W-1:0]   ovl_row;

  stage_t             stage_d, stage_q;
  logic               valid_d, valid_q;
  logic               rom_rd_d, rom_rd_q;
  logic [RADDR_W-1:0] rom_addr_d, rom_addr_q;

  blink_div #(.DIV_W(BLINK_DIV_W)) blink_i (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase)
  );

  glyph_store #(.ADDR_W(GA_W)) store_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (req_valid && user_sel),
    .rd_addr ({req_code[SEL_W-1:0], req_row}),
    .rd_data (ram_row)
  );

  // Next-state logic
  always_comb begin
    user_sel           = (req_code[CODE_W-1:SEL_W] == '0);
    valid_d            = req_valid;
    rom_rd_d           = req_valid && !user_sel;
    rom_addr_d         = rom_addr_q;
    if (req_valid && !user_sel) begin
      rom_addr_d = {req_code, req_row};
    end
    stage_d.user       = user_sel;
    stage_d.underline  = cursor_en && req_on_cursor && (req_row == '1);
    stage_d.blink_on   = blink_en && req_on_cursor && phase;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      rom_rd_q   <= 1'b0;
      rom_addr_q <= '0;
      stage_q    <= '0;
    end else begin
      valid_q    <= valid_d;
      rom_rd_q   <= rom_rd_d;
      rom_addr_q <= rom_addr_d;
      if (req_valid) begin
        stage_q <= stage_d;
      end
    end
  end

  row_overlay ovl_i (
    .st      (stage_q),
    .ram_row (ram_row),
    .rom_row (rom_data),
    .pix     (ovl_row)
  );

  assign out_valid = valid_q;
  assign rom_rd    = rom_rd_q;
  assign rom_addr  = rom_addr_q;
  assign pix_row   = valid_q ? ovl_row : '0;

  // Assertions
  AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R2
  AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid && (pix_row == '0)); // R2
  AST_FONT_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_code[CODE_W-1:SEL_W] != '0)) |=>
      (rom_rd && (rom_addr == $past({req_code, req_row})))); // R4
  AST_FONT_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_code[CODE_W-1:SEL_W] == '0)) |=>
      (!rom_rd && $stable(rom_addr))); // R5
  AST_CURSOR_UNDERLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cursor_en && req_on_cursor && (req_row == '1)) |=>
      (pix_row == '1)); // R9
  AST_ROM_RD_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |-> out_valid); // R4
endmodule

// File: tb/glyph_row_fetch_tb_top.sv
module glyph_row_fetch_tb_top;
  localparam int BD = 3;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [7:0]  req_code;
  logic [2:0]  req_row;
  logic        req_on_cursor;
  logic        cursor_en;
  logic        blink_en;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [4:0]  wr_data;
  logic        rom_rd;
  logic [10:0] rom_addr;
  logic [4:0]  rom_data;
  logic        out_valid;
  logic [4:0]  pix_row;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  typedef struct {
    logic [4:0]  pix;
    logic        font;
    logic [10:0] addr;
    int          rq;
  } exp_t;

  exp_t        sb_q[$];
  logic [4:0]  gl_model [32];
  logic [10:0] last_font_addr;
  logic [BD:0] tb_cnt;

  glyph_row_fetch #(.BLINK_DIV_W(BD)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .req_row(req_row), .req_on_cursor(req_on_cursor), .cursor_en(cursor_en),
    .blink_en(blink_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
    .out_valid(out_valid), .pix_row(pix_row)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [4:0] rom_fn(input logic [10:0] a);
    logic [10:0] t;
    t = a * 11'd13 + (a >> 4) + 11'd7;
    return t[4:0];
  endfunction

  assign rom_data = rom_fn(rom_addr);

  // Blink phase counter per R10
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_cnt <= '0;
    else        tb_cnt <= tb_cnt + 1'b1;
  end

  task automatic check(input bit ok, input int rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Driver: one request per call, called just after a falling edge
  task automatic send(input logic [7:0] code, input logic [2:0] row,
                      input bit cur, input bit cen, input bit ben, input int rq);
    exp_t e;
    logic [4:0] p;
    bit font;
    font = (code[7:2] != 6'd0);
    if (font) begin
      p = rom_fn({code, row});
      last_font_addr = {code, row};
    end else begin
      p = gl_model[{code[1:0], row}];
    end
    if (ben && cur && tb_cnt[BD]) p = 5'h1F;
    if (cen && cur && row == 3'd7) p = 5'h1F;
    e.pix = p; e.font = font; e.addr = last_font_addr; e.rq = rq;
    sb_q.push_back(e);
    req_valid = 1'b1; req_code = code; req_row = row;
    req_on_cursor = cur; cursor_en = cen; blink_en = ben;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0; wr_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic write_row(input logic [4:0] a, input logic [4:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    gl_model[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Monitor: pops expected items as results appear
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, 2, "unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(pix_row == e.pix, e.rq, "pix_row", pix_row, e.pix);
          check(rom_rd == e.font, e.font ? 4 : 5, "rom_rd", rom_rd, e.font);
          check(rom_addr == e.addr, e.font ? 4 : 5, "rom_addr", rom_addr, e.addr);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, 2, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_code = '0; req_row = '0;
    req_on_cursor = 1'b0; cursor_en = 1'b0; blink_en = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    last_font_addr = '0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs in reset
    check(out_valid == 1'b0 && rom_rd == 1'b0 && pix_row == 5'd0, 1,
          "reset outputs", {out_valid, rom_rd, pix_row}, 0);
    rst_n = 1'b1;
    idle(2);
    check(out_valid == 1'b0 && rom_rd == 1'b0 && pix_row == 5'd0, 1,
          "idle after reset", {out_valid, rom_rd, pix_row}, 0);

    // R6: fill the glyph RAM
    for (int a = 0; a < 32; a++) write_row(5'(a), 5'((a * 7 + 3) ^ (a >> 2)));
    idle(1);

    // R3, R8: read every user row, cursor disabled (row 7 shown as stored)
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 8; r++) send(8'(c), 3'(r), 1'b0, 1'b0, 1'b0, 3);
    idle(2);
    // R8: cursor cell, cursor off, row 7 keeps its dots
    send(8'd2, 3'd7, 1'b1, 1'b0, 1'b0, 8);
    send(8'd3, 3'd7, 1'b1, 1'b0, 1'b0, 8);
    idle(2);

    // R4: font codes just above the glyph range and at the top
    send(8'd4,   3'd0, 1'b0, 1'b0, 1'b0, 4);
    send(8'h20,  3'd5, 1'b0, 1'b0, 1'b0, 4);
    send(8'hFC,  3'd3, 1'b0, 1'b0, 1'b0, 4);
    send(8'hFF,  3'd7, 1'b0, 1'b0, 1'b0, 4);
    // R5: user request after font keeps font address
    send(8'd1,   3'd2, 1'b0, 1'b0, 1'b0, 5);
    send(8'd0,   3'd6, 1'b0, 1'b0, 1'b0, 5);
    send(8'h80,  3'd1, 1'b0, 1'b0, 1'b0, 4);
    idle(1);
    send(8'd3,   3'd4, 1'b0, 1'b0, 1'b0, 5);
    idle(2);

    // R6: overwrite one row and read it back
    write_row(5'd13, 5'h15);
    idle(1);
    send(8'd1, 3'd5, 1'b0, 1'b0, 1'b0, 6);
    idle(2);

    // R9: cursor underline
    send(8'd1,  3'd7, 1'b1, 1'b1, 1'b0, 9);
    send(8'h41, 3'd7, 1'b1, 1'b1, 1'b0, 9);
    send(8'd1,  3'd3, 1'b1, 1'b1, 1'b0, 9);
    send(8'h41, 3'd7, 1'b0, 1'b1, 1'b0, 9);
    send(8'd2,  3'd7, 1'b0, 1'b1, 1'b0, 9);
    idle(2);

    // R10: blink over several phases, cursor cell and other cells
    for (int k = 0; k < 40; k++)
      send((k % 3 == 0) ? 8'h35 : 8'(k % 4), 3'(k % 7), 1'b1, 1'b0, 1'b1, 10);
    for (int k = 0; k < 20; k++)
      send(8'(k % 4), 3'(k % 8), 1'b0, 1'b0, 1'b1, 10);
    idle(3);

    // R7: glyph contents survive reset
    rst_n = 1'b0;
    idle(2);
    check(out_valid == 1'b0 && rom_rd == 1'b0 && rom_addr == 11'd0, 1,
          "second reset", {out_valid, rom_rd, rom_addr}, 0);
    last_font_addr = '0;
    rst_n = 1'b1;
    idle(1);
    for (int r = 0; r < 8; r++) send(8'd2, 3'(r), 1'b0, 1'b0, 1'b0, 7);
    send(8'd1, 3'd5, 1'b0, 1'b0, 1'b0, 7);
    idle(3);
    check(sb_q.size() == 0, 2, "results missing", sb_q.size(), 0);
    report();
  end
endmodule